// File: doc/BRIEF.md
# Power-Down Clock Sequencer

This block sequences a clock generator into and out of a low-power state. An active-low power-down request arrives asynchronously. It is synchronized, and then the CPU-domain and PCI-domain output clocks are parked low. Each domain parks only at its own cycle boundary, so no pulse is ever cut short. Once both domains are parked, the oscillator and VCO enables are dropped.

When the request is released, both enables come back together. A counted stabilization window then runs. Only after that window are the gated clocks let through again, and each domain starts at the beginning of a full high half-period. A status flag is high only while the clocks are in normal operation.

The two domain clocks come from internal phase counters that run off the sequencing clock while the VCO enable is high. The gated clock of each domain is the registered AND of its phase level and its enable. That gated clock is what the block drives out.

Top module: `pdn_clk_seq`

## Requirements
- R1: `pd_req_n` passes through a two-stage synchronizer. A change on it affects the sequence at the third rising `clk` edge after the change. A low level held for a single `clk` period is still acted upon.
- R2: While `rst_n` is low, every output is 0. Internal reset ends two `clk` edges after `rst_n` rises, and the sequencer starts in the off state.
- R3: From the off state, once the synchronized request is high, `osc_en` and `vco_en` rise together. `run_ok` then rises exactly STAB_CYCLES `clk` edges after `vco_en` rose.
- R4: `run_ok` is 1 only in the run state. It is 0 during the off, wake and drain states. It falls on the edge at which the synchronized request is seen low.
- R5: Every high pulse on `cpu_clk` lasts exactly CPU_HALF `clk` cycles. Every high pulse on `pci_clk` lasts exactly PCI_HALF `clk` cycles.
- R6: While `vco_en` is 0, each domain's phase counter is held at the start of its low half. A domain enable changes only at that domain's rising boundary, which is where the low half ends. At that boundary the enable is set if the sequencer is in the run state and is cleared otherwise.
- R7: `osc_en` and `vco_en` fall only after both `cpu_en` and `pci_en` are 0. They fall one edge after the drain state sees both enables at 0.
- R8: If the request returns high during drain, the shutdown is not cancelled. The sequence still reaches the off state and then wakes again.
- R9: `cpu_en` and `cpu_clk` are both 0 no later than 3 + 2*CPU_HALF `clk` edges after `pd_req_n` falls. With CPU_HALF = 2 this is under two CPU clock periods.
- R10: A request that goes low during the wake state returns the sequencer to the off state without `run_ok` ever rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | PLL/VCO enable |
| cpu_en | output | 1 | CPU-domain clock-gate enable |
| pci_en | output | 1 | PCI-domain clock-gate enable |
| cpu_clk | output | 1 | Gated CPU-domain clock |
| pci_clk | output | 1 | Gated PCI-domain clock |
| run_ok | output | 1 | High only in normal running operation |

## Verification
The bench builds the block with CPU_HALF = 2, PCI_HALF = 5 and STAB_CYCLES = 24. With these values a full wake window and a drain that waits on the slower PCI boundary both fit in a few dozen cycles. Every phase offset of the CPU domain can then be hit simply by varying when the request falls. The short window also allows a request to be dropped in the middle of wake and a request to bounce back during drain within one short run.

// File: rtl/pdn_seq_pkg.sv
package pdn_seq_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_WAKE  = 2'd1,
    PS_RUN   = 2'd2,
    PS_DRAIN = 2'd3
  } pdn_state_t;

  localparam int unsigned NUM_DOM = 2;
  localparam int unsigned DOM_CPU = 0;
  localparam int unsigned DOM_PCI = 1;
endpackage

// File: rtl/pdn_sync2.sv
module pdn_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pdn_clk_gate.sv
module pdn_clk_gate #(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_src,
  input  logic release_i,
  output logic en_o,
  output logic clk_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          en_q, en_d;
  logic          out_q, out_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    en_d  = en_q;
    if (!run_src) begin
      cnt_d = '0;
      lvl_d = 1'b0;
      en_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
      if (!lvl_q) en_d = release_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    out_d = lvl_d & en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign en_o  = en_q;
  assign clk_o = out_q;
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_seq_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake_req,
  input  logic all_parked,
  output logic osc_en,
  output logic vco_en,
  output logic release_o,
  output logic run_ok
);
  localparam int unsigned SW = $clog2(STAB_CYCLES + 1) + 1;
  localparam logic [SW-1:0] STAB_LAST = SW'(STAB_CYCLES - 1);

  pdn_state_t    st_q, st_d;
  logic [SW-1:0] stab_q, stab_d;
  logic          stab_ce;

  assign stab_ce = (st_q == PS_WAKE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_OFF:   if (awake_req) st_d = PS_WAKE;
      PS_WAKE: begin
        if (!awake_req)               st_d = PS_OFF;
        else if (stab_q == STAB_LAST) st_d = PS_RUN;
      end
      PS_RUN:   if (!awake_req) st_d = PS_DRAIN;
      PS_DRAIN: if (all_parked) st_d = PS_OFF;
      default:  st_d = PS_OFF;
    endcase
  end

  always_comb begin
    stab_d = '0;
    if (stab_ce) stab_d = stab_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_OFF;
      stab_q <= '0;
    end else begin
      st_q   <= st_d;
      stab_q <= stab_d;
    end
  end

  assign osc_en    = (st_q != PS_OFF);
  assign vco_en    = (st_q != PS_OFF);
  assign release_o = (st_q == PS_RUN);
  assign run_ok    = (st_q == PS_RUN);
endmodule

// File: rtl/pdn_clk_seq.sv
module pdn_clk_seq
  import pdn_seq_pkg::*;
#(
  parameter int unsigned CPU_HALF    = 2,
  parameter int unsigned PCI_HALF    = 6,
  parameter int unsigned STAB_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req_n,
  output logic osc_en,
  output logic vco_en,
  output logic cpu_en,
  output logic pci_en,
  output logic cpu_clk,
  output logic pci_clk,
  output logic run_ok
);
  logic               core_rst_n;
  logic               awake_req;
  logic               vco_on;
  logic               rel;
  logic [NUM_DOM-1:0] dom_en;
  logic [NUM_DOM-1:0] dom_clk;

  pdn_sync2 u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (core_rst_n)
  );

  pdn_sync2 u_req_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (pd_req_n),
    .q     (awake_req)
  );

  pdn_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .awake_req  (awake_req),
    .all_parked (~|dom_en),
    .osc_en     (osc_en),
    .vco_en     (vco_on),
    .release_o  (rel),
    .run_ok     (run_ok)
  );

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    localparam int unsigned H = (g == DOM_CPU) ? CPU_HALF : PCI_HALF;
    pdn_clk_gate #(.HALF(H)) u_gate (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .run_src   (vco_on),
      .release_i (rel),
      .en_o      (dom_en[g]),
      .clk_o     (dom_clk[g])
    );
  end

  assign vco_en  = vco_on;
  assign cpu_en  = dom_en[DOM_CPU];
  assign pci_en  = dom_en[DOM_PCI];
  assign cpu_clk = dom_clk[DOM_CPU];
  assign pci_clk = dom_clk[DOM_PCI];
endmodule

// File: rtl/pdn_clk_seq_chk.sv
module pdn_clk_seq_chk #(
  parameter int unsigned CPU_HALF    = 2,
  parameter int unsigned PCI_HALF    = 6,
  parameter int unsigned STAB_CYCLES = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic vco_en,
  input logic cpu_en,
  input logic pci_en,
  input logic cpu_clk,
  input logic pci_clk,
  input logic run_ok
);
  localparam int unsigned WW = $clog2(STAB_CYCLES + 2) + 1;
  localparam int unsigned CHW = $clog2(CPU_HALF + 2) + 1;
  localparam int unsigned PHW = $clog2(PCI_HALF + 2) + 1;

  logic [WW-1:0]  wcnt;
  logic [CHW-1:0] hc_cpu;
  logic [PHW-1:0] hc_pci;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt   <= '0;
      hc_cpu <= '0;
      hc_pci <= '0;
    end else begin
      if (!vco_en)                     wcnt <= '0;
      else if (!run_ok && !(&wcnt))    wcnt <= wcnt + 1'b1;
      if (!cpu_clk)                    hc_cpu <= '0;
      else if (!(&hc_cpu))             hc_cpu <= hc_cpu + 1'b1;
      if (!pci_clk)                    hc_pci <= '0;
      else if (!(&hc_pci))             hc_pci <= hc_pci + 1'b1;
    end
  end

  p_stab_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_ok) |-> (wcnt == WW'(STAB_CYCLES)));

  p_status_needs_osc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |-> (osc_en && vco_en));

  p_cpu_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk) |-> (hc_cpu == CHW'(CPU_HALF)));

  p_pci_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_clk) |-> (hc_pci == PHW'(PCI_HALF)));

  p_gate_needs_vco_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en || pci_en || cpu_clk || pci_clk) |-> vco_en);

  p_vco_off_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vco_en) |-> (!$past(cpu_en) && !$past(pci_en) && !cpu_clk && !pci_clk));
endmodule

bind pdn_clk_seq pdn_clk_seq_chk #(
  .CPU_HALF    (CPU_HALF),
  .PCI_HALF    (PCI_HALF),
  .STAB_CYCLES (STAB_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .osc_en  (osc_en),
  .vco_en  (vco_en),
  .cpu_en  (cpu_en),
  .pci_en  (pci_en),
  .cpu_clk (cpu_clk),
  .pci_clk (pci_clk),
  .run_ok  (run_ok)
);

// File: tb/sim_pdn_clk_seq.sv
`timescale 1ns/1ps
module sim_pdn_clk_seq;
  localparam int CH = 2;
  localparam int PH = 5;
  localparam int SC = 24;

  logic clk;
  logic rst_n;
  logic pd_req_n;
  logic osc_en, vco_en, cpu_en, pci_en, cpu_clk, pci_clk, run_ok;

  int checks;
  int failures;
  int cyc;

  pdn_clk_seq #(.CPU_HALF(CH), .PCI_HALF(PH), .STAB_CYCLES(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n),
    .osc_en(osc_en), .vco_en(vco_en), .cpu_en(cpu_en), .pci_en(pci_en),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .run_ok(run_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: 0 off, 1 wake, 2 run, 3 drain
  int m_rs1, m_rs2, m_s1, m_s2, m_st, m_cnt;
  int m_cph, m_pph, m_cen, m_pen, m_cclk, m_pclk;
  int run_cpu, run_pci;
  int n_st, n_cnt, vco, rel;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0;
      m_cph = 0; m_pph = 0; m_cen = 0; m_pen = 0; m_cclk = 0; m_pclk = 0;
    end else begin
      if (m_rs2 == 1) begin
        vco = (m_st != 0);
        rel = (m_st == 2);
        case (m_st)
          0: n_st = m_s2 ? 1 : 0;
          1: n_st = !m_s2 ? 0 : ((m_cnt == SC - 1) ? 2 : 1);
          2: n_st = m_s2 ? 2 : 3;
          default: n_st = (m_cen == 0 && m_pen == 0) ? 0 : 3;
        endcase
        n_cnt = (m_st == 1) ? m_cnt + 1 : 0;
        if (!vco) begin
          m_cph = 0; m_cen = 0; m_cclk = 0;
          m_pph = 0; m_pen = 0; m_pclk = 0;
        end else begin
          m_cph = (m_cph + 1) % (2 * CH);
          if (m_cph == CH) m_cen = rel;
          m_cclk = (m_cph >= CH && m_cen == 1) ? 1 : 0;
          m_pph = (m_pph + 1) % (2 * PH);
          if (m_pph == PH) m_pen = rel;
          m_pclk = (m_pph >= PH && m_pen == 1) ? 1 : 0;
        end
        m_s2 = m_s1;
        m_s1 = pd_req_n;
        m_st = n_st;
        m_cnt = n_cnt;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
    #1;
    check("R3", "osc_en", osc_en, m_st != 0);
    check("R7", "vco_en", vco_en, m_st != 0);
    check("R4", "run_ok", run_ok, m_st == 2);
    check("R6", "cpu_en", cpu_en, m_cen);
    check("R6", "pci_en", pci_en, m_pen);
    check("R1", "cpu_clk", cpu_clk, m_cclk);
    check("R6", "pci_clk", pci_clk, m_pclk);
    if (cpu_clk) run_cpu++;
    else begin
      if (run_cpu != 0) check("R5", "cpu high width", run_cpu, CH);
      run_cpu = 0;
    end
    if (pci_clk) run_pci++;
    else begin
      if (run_pci != 0) check("R5", "pci high width", run_pci, PH);
      run_pci = 0;
    end
  end

  task automatic wait_run();
    int n = 0;
    while (!run_ok && n < 500) begin
      @(posedge clk); #2; n++;
    end
    check("R3", "reached run", run_ok, 1);
  endtask

  task automatic wait_off();
    int n = 0;
    while (osc_en && n < 500) begin
      @(posedge clk); #2; n++;
    end
    check("R7", "reached off", osc_en, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shutdown_at(input int offset);
    int t0, lat;
    idle(offset);
    @(negedge clk);
    pd_req_n = 1'b0;
    t0 = cyc;
    lat = 0;
    while ((cpu_en || cpu_clk) && lat < 100) begin
      @(posedge clk); #2;
      lat = cyc - t0;
    end
    check("R9", "cpu parked within bound", (lat <= 3 + 2 * CH) ? 1 : 0, 1);
    wait_off();
    idle(6);
    check("R7", "osc stays off", osc_en, 0);
    @(negedge clk);
    pd_req_n = 1'b1;
    wait_run();
  endtask

  initial begin
    int seen_off;
    checks = 0; failures = 0; cyc = 0;
    run_cpu = 0; run_pci = 0;
    rst_n = 1'b0;
    pd_req_n = 1'b1;
    idle(4);
    check("R2", "osc_en in reset", osc_en, 0);
    check("R2", "run_ok in reset", run_ok, 0);
    check("R2", "cpu_clk in reset", cpu_clk, 0);
    rst_n = 1'b1;
    idle(3);
    check("R2", "still off after release", vco_en, 0);
    wait_run();
    idle(30);
    check("R6", "cpu gate open in run", cpu_en, 1);
    for (int k = 0; k < 4; k++) begin
      shutdown_at(20 + k);
      idle(15);
    end

    // R10: request drops during wake
    @(negedge clk); pd_req_n = 1'b0;
    wait_off();
    @(negedge clk); pd_req_n = 1'b1;
    while (!vco_en) @(negedge clk);
    idle(5);
    pd_req_n = 1'b0;
    idle(4);
    check("R10", "back to off from wake", osc_en, 0);
    check("R10", "no run during aborted wake", run_ok, 0);
    @(negedge clk); pd_req_n = 1'b1;
    wait_run();
    idle(25);

    // R8: request bounces high during drain
    @(negedge clk); pd_req_n = 1'b0;
    idle(2);
    pd_req_n = 1'b1;
    seen_off = 0;
    for (int i = 0; i < 200 && !(seen_off == 1 && run_ok); i++) begin
      @(posedge clk); #2;
      if (!osc_en) seen_off = 1;
    end
    check("R8", "drain completed to off", seen_off, 1);
    check("R8", "woke again after bounce", run_ok, 1);

    // R1: single-cycle low still acted upon
    idle(25);
    @(negedge clk); pd_req_n = 1'b0;
    @(negedge clk); pd_req_n = 1'b1;
    idle(2);
    check("R1", "short request leaves run", run_ok, 0);
    wait_run();
    idle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule